// File: doc/BRIEF.md
# Three-Stage Multiply-Accumulate Unit

This unit sits next to a simple processor datapath. Each operation it accepts carries two operands and three selectors: an operation code (multiply only, multiply-add or multiply-subtract), an arithmetic format (signed integer, unsigned integer or signed fractional) and an operand width (16 or 32 bits). Every operation goes through three registered stages: operand formatting, multiply, then accumulate. The stages read and write a single 32-bit accumulator. One 16x16 operation can be accepted per clock.

A register port lets software load the accumulator and the status bits, and read the accumulator back. Loads travel down the same pipeline as arithmetic operations, so they stay in program order. A read is held off until no operation is left in the first two stages, so it always returns a value that includes every earlier operation. Signed accumulation sets a sticky overflow flag. An optional saturate bit clamps the result instead of letting it wrap.

Top module: `mac_unit`

## Requirements
- R1: Operation codes on `iss_op`: 00 and 11 write the product to the accumulator, 01 adds the product to it, and 10 subtracts the product from it.
- R2: Suppose an operation is accepted at clock edge k. The accumulator holds its result after edge k+2. Operations accepted on consecutive edges all take effect.
- R3: Format codes on `iss_fmt`: 00 is signed integer, 01 is unsigned integer, 10 is signed fractional, and 11 acts as signed integer. With `iss_wide`=0 only bits 15:0 of each operand are used, sign-extended or zero-extended according to the format.
- R4: Integer formats with 32-bit operands keep bits 31:0 of the full product.
- R5: In fractional format the product is doubled. For 16-bit operands the result is the 31-bit product followed by a zero bit. For 32-bit operands the result is bits 62:31 of the full product.
- R6: In fractional format, when both operands are the most negative value of the chosen width, the product becomes 0x7FFFFFFF.
- R7: In signed formats, an add or subtract whose true result does not fit in 32 bits sets `ovf_flag`. In unsigned format, accumulation never sets the flag.
- R8: When `sat_mode` is 1, an overflowing signed add or subtract stores 0x7FFFFFFF if the true result is positive and 0x80000000 if it is negative. When `sat_mode` is 0 the result wraps.
- R9: `ovf_flag` stays set until a status write. A status write copies data bit 0 into `ovf_flag` and data bit 1 into `sat_mode`.
- R10: `rd_valid` is high only while `rd_req` is high and the first two stages are empty. `rd_data` then includes every operation and load accepted earlier.
- R11: With `wr_en` high, `wr_sel`=0 loads the accumulator and `wr_sel`=1 loads the status bits. A write is applied two edges after it is accepted. It lands after operations accepted earlier and before operations accepted later.
- R12: `iss_ready` is low whenever `wr_en` or `rd_req` is high. An operation is accepted only on an edge where both `iss_valid` and `iss_ready` are high.
- R13: After reset the accumulator is 0, `ovf_flag` and `sat_mode` are 0, and a read completes at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | 1 | An operation is offered |
| iss_ready | output | 1 | The unit can accept an operation this cycle |
| iss_op | input | 2 | Operation code |
| iss_fmt | input | 2 | Arithmetic format |
| iss_wide | input | 1 | 1 selects 32-bit operands, 0 selects 16-bit operands |
| iss_a | input | 32 | First operand |
| iss_b | input | 32 | Second operand |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 is the accumulator, 1 is status |
| wr_data | input | 32 | Write data |
| rd_req | input | 1 | Accumulator read request |
| rd_valid | output | 1 | Read data is valid |
| rd_data | output | 32 | Accumulator value |
| ovf_flag | output | 1 | Sticky overflow flag |
| sat_mode | output | 1 | Saturate enable |

## Verification
A table of single operations covers each format at both widths. Its entries are chosen to tell apart sign extension from zero extension, the low and high product slices, the fractional doubling, and the -1 x -1 corner. Overflow entries at the positive and negative limits are run with saturation off and on, which separates wrapping from clamping and shows that unsigned wrap leaves the flag clear. Directed sequences then check pipeline timing and the issue rate. Further sequences place a load between two operations, hold an operation against a pending read, and test flag stickiness.

// File: rtl/mac_pkg.sv
// Shared types for the multiply-accumulate unit.
// Assumes an accumulator width that is twice the narrow operand width.
package mac_pkg;
    localparam int W  = 32;      // accumulator and wide operand width
    localparam int HW = W / 2;   // narrow operand width

    typedef enum logic [2:0] {K_MUL, K_MAC, K_MSU, K_LDACC, K_LDSTAT} kind_e;
    typedef enum logic [1:0] {F_SINT = 2'd0, F_UINT = 2'd1, F_FRAC = 2'd2, F_RSV = 2'd3} fmt_e;

    // entry held after operand formatting
    typedef struct packed {
        logic          valid;
        kind_e         kind;
        fmt_e          fmt;
        logic          wide;
        logic [W:0]    a;
        logic [W:0]    b;
        logic          neg1sq;
    } s1_t;

    // entry held after the multiply
    typedef struct packed {
        logic          valid;
        kind_e         kind;
        fmt_e          fmt;
        logic [W-1:0]  val;
    } s2_t;
endpackage

// File: rtl/mac_fmt.sv
// Stage 1: widens the operands to W+1 bits, sign- or zero-extending by format
// and width, and flags the fractional -1 x -1 case.
// Assumes loads arrive with wide=1 so that the data passes through unchanged.
module mac_fmt
    import mac_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  kind_e         kind,
    input  fmt_e          fmt,
    input  logic          wide,
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    output s1_t           s1_q
);
    localparam logic [W-1:0]  MINW = {1'b1, {(W-1){1'b0}}};
    localparam logic [HW-1:0] MINH = {1'b1, {(HW-1){1'b0}}};

    logic sgn;
    logic [W:0] a_x, b_x;
    logic n1;

    // extend operands to a common signed width
    always_comb begin
        sgn = (fmt != F_UINT);
        a_x = wide ? {sgn & a[W-1], a} : {{(W-HW+1){sgn & a[HW-1]}}, a[HW-1:0]};
        b_x = wide ? {sgn & b[W-1], b} : {{(W-HW+1){sgn & b[HW-1]}}, b[HW-1:0]};
        n1  = (fmt == F_FRAC) &&
              (wide ? (a == MINW && b == MINW) : (a[HW-1:0] == MINH && b[HW-1:0] == MINH));
    end

    // stage register
    always_ff @(posedge clk) begin
        if (!rst_n) s1_q <= '0;
        else begin
            s1_q.valid  <= take;
            s1_q.kind   <= kind;
            s1_q.fmt    <= fmt;
            s1_q.wide   <= wide;
            s1_q.a      <= a_x;
            s1_q.b      <= b_x;
            s1_q.neg1sq <= n1;
        end
    end
endmodule

// File: rtl/mac_mult.sv
// Stage 2: multiplies the extended operands and picks the 32-bit product
// slice for integer or fractional format. Loads pass their data through.
module mac_mult
    import mac_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  s1_t  s1,
    output s2_t  s2_q
);
    localparam logic [W-1:0] MAXPOS = {1'b0, {(W-1){1'b1}}};

    logic signed [2*W+1:0] prod;
    logic [W-1:0] slice;
    logic unused_prod;

    // full product and slice selection
    always_comb begin
        prod = $signed(s1.a) * $signed(s1.b);
        if (s1.kind == K_LDACC || s1.kind == K_LDSTAT) slice = s1.a[W-1:0];
        else if (s1.fmt == F_FRAC) begin
            if (s1.neg1sq)   slice = MAXPOS;
            else if (s1.wide) slice = prod[2*W-2:W-1];
            else              slice = {prod[2*HW-2:0], 1'b0};
        end else slice = prod[W-1:0];
    end
    assign unused_prod = ^{prod[2*W+1:2*W-1], s1.wide};

    // stage register
    always_ff @(posedge clk) begin
        if (!rst_n) s2_q <= '0;
        else begin
            s2_q.valid <= s1.valid;
            s2_q.kind  <= s1.kind;
            s2_q.fmt   <= s1.fmt;
            s2_q.val   <= slice;
        end
    end

    assert_frac_neg1_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s1.valid && s1.neg1sq && s1.kind != K_LDACC && s1.kind != K_LDSTAT) |=> (s2_q.val == MAXPOS));
endmodule

// File: rtl/mac_accum.sv
// Stage 3: owns the accumulator and the status bits. It writes, adds or
// subtracts the product, flags signed overflow, and saturates when asked.
module mac_accum
    import mac_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  s2_t           s2,
    output logic [W-1:0]  acc_q,
    output logic          ovf_q,
    output logic          sat_q
);
    localparam logic [W-1:0] MAXPOS = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MINNEG = {1'b1, {(W-1){1'b0}}};

    logic [W:0] sum;
    logic ov, sgn;

    // W+1-bit sum or difference with overflow detection
    always_comb begin
        if (s2.kind == K_MSU) sum = {acc_q[W-1], acc_q} - {s2.val[W-1], s2.val};
        else                  sum = {acc_q[W-1], acc_q} + {s2.val[W-1], s2.val};
        ov  = sum[W] ^ sum[W-1];
        sgn = (s2.fmt != F_UINT);
    end

    // accumulator and status update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            ovf_q <= 1'b0;
            sat_q <= 1'b0;
        end else if (s2.valid) begin
            case (s2.kind)
                K_MAC, K_MSU: begin
                    if (sgn && ov) ovf_q <= 1'b1;
                    if (sgn && ov && sat_q) acc_q <= sum[W] ? MINNEG : MAXPOS;
                    else                    acc_q <= sum[W-1:0];
                end
                K_LDSTAT: begin
                    ovf_q <= s2.val[0];
                    sat_q <= s2.val[1];
                end
                default: acc_q <= s2.val;
            endcase
        end
    end

    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !(s2.valid && s2.kind == K_LDSTAT)) |=> ovf_q);
    assert_uint_no_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (s2.valid && s2.fmt == F_UINT && s2.kind != K_LDSTAT && !ovf_q) |=> !ovf_q);
    assert_mul_loads_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (s2.valid && s2.kind == K_MUL) |=> (acc_q == $past(s2.val)));
endmodule

// File: rtl/mac_unit.sv
// Top of the multiply-accumulate unit. It merges register writes into the
// operation stream, holds issue off during writes and reads, and releases a
// read only once the first two stages are empty.
module mac_unit
    import mac_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          iss_valid,
    output logic          iss_ready,
    input  logic [1:0]    iss_op,
    input  logic [1:0]    iss_fmt,
    input  logic          iss_wide,
    input  logic [31:0]   iss_a,
    input  logic [31:0]   iss_b,
    input  logic          wr_en,
    input  logic          wr_sel,
    input  logic [31:0]   wr_data,
    input  logic          rd_req,
    output logic          rd_valid,
    output logic [31:0]   rd_data,
    output logic          ovf_flag,
    output logic          sat_mode
);
    logic take, wide_m;
    kind_e kind_m;
    logic [W-1:0] a_m;
    s1_t s1;
    s2_t s2;

    // a write takes the issue slot; otherwise a handshaked operation enters
    always_comb begin
        iss_ready = !wr_en && !rd_req;
        take      = wr_en || (iss_valid && iss_ready);
        wide_m    = wr_en ? 1'b1 : iss_wide;
        a_m       = wr_en ? wr_data : iss_a;
        if (wr_en) kind_m = wr_sel ? K_LDSTAT : K_LDACC;
        else case (iss_op)
            2'b01:   kind_m = K_MAC;
            2'b10:   kind_m = K_MSU;
            default: kind_m = K_MUL;
        endcase
    end

    mac_fmt u_fmt (
        .clk(clk), .rst_n(rst_n), .take(take), .kind(kind_m),
        .fmt(fmt_e'(iss_fmt)), .wide(wide_m), .a(a_m), .b(iss_b), .s1_q(s1)
    );

    mac_mult u_mult (.clk(clk), .rst_n(rst_n), .s1(s1), .s2_q(s2));

    mac_accum u_acc (
        .clk(clk), .rst_n(rst_n), .s2(s2),
        .acc_q(rd_data), .ovf_q(ovf_flag), .sat_q(sat_mode)
    );

    // read completes once nothing is left in the first two stages
    assign rd_valid = rd_req && !s1.valid && !s2.valid;

    assert_issue_enters_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_ready) |=> s1.valid);
    assert_read_retired_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (s1.valid && rd_req) |=> !rd_valid);
endmodule

// File: tb/mac_unit_bench.sv
// Bench for mac_unit: a vector table of single operations, then directed tests.
module mac_unit_bench;
    logic clk = 1'b0, rst_n = 1'b0;
    logic iss_valid = 0, iss_ready, iss_wide = 0, wr_en = 0, wr_sel = 0, rd_req = 0;
    logic [1:0] iss_op = 0, iss_fmt = 0;
    logic [31:0] iss_a = 0, iss_b = 0, wr_data = 0, rd_data;
    logic rd_valid, ovf_flag, sat_mode;
    int n_chk = 0, n_fail = 0;
    logic [31:0] got;

    always #5 clk = ~clk;

    mac_unit u_mac_unit (.*);

    typedef struct packed {
        logic [1:0] op; logic [1:0] fmt; logic wide; logic sat;
        logic [31:0] a; logic [31:0] b; logic [31:0] init; logic [31:0] exp;
        logic eovf; int req;
    } vec_t;

    localparam vec_t VECS [15] = '{
        '{2'd0, 2'd0, 1'b0, 1'b0, 32'h3,        32'hFFFE,     32'h12345678, 32'hFFFFFFFA, 1'b0, 1},  // R1 R3
        '{2'd1, 2'd1, 1'b0, 1'b0, 32'hFFFF,     32'hFFFF,     32'h00020000, 32'h00000001, 1'b0, 7},  // R7
        '{2'd2, 2'd0, 1'b0, 1'b0, 32'h10,       32'h10,       32'h100,      32'h0,        1'b0, 1},  // R1
        '{2'd0, 2'd0, 1'b1, 1'b0, 32'h00010000, 32'h00010001, 32'h0,        32'h00010000, 1'b0, 4},  // R4
        '{2'd0, 2'd0, 1'b0, 1'b0, 32'hABCD0002, 32'h12340003, 32'h0,        32'h6,        1'b0, 3},  // R3
        '{2'd0, 2'd2, 1'b0, 1'b0, 32'h4000,     32'h4000,     32'h0,        32'h20000000, 1'b0, 5},  // R5
        '{2'd0, 2'd2, 1'b0, 1'b0, 32'h8000,     32'h8000,     32'h0,        32'h7FFFFFFF, 1'b0, 6},  // R6
        '{2'd0, 2'd2, 1'b1, 1'b0, 32'h80000000, 32'h80000000, 32'h0,        32'h7FFFFFFF, 1'b0, 6},  // R6
        '{2'd0, 2'd2, 1'b1, 1'b0, 32'h40000000, 32'hC0000000, 32'h0,        32'hE0000000, 1'b0, 5},  // R5
        '{2'd1, 2'd0, 1'b0, 1'b0, 32'h1,        32'h1,        32'h7FFFFFFF, 32'h80000000, 1'b1, 7},  // R7
        '{2'd1, 2'd0, 1'b0, 1'b1, 32'h1,        32'h1,        32'h7FFFFFFF, 32'h7FFFFFFF, 1'b1, 8},  // R8
        '{2'd2, 2'd0, 1'b0, 1'b1, 32'h1,        32'h1,        32'h80000000, 32'h80000000, 1'b1, 8},  // R8
        '{2'd1, 2'd2, 1'b0, 1'b0, 32'h4000,     32'h4000,     32'h60000000, 32'h80000000, 1'b1, 7},  // R7
        '{2'd2, 2'd2, 1'b1, 1'b0, 32'h40000000, 32'h40000000, 32'h0,        32'hE0000000, 1'b0, 5},  // R5
        '{2'd0, 2'd1, 1'b1, 1'b0, 32'hFFFFFFFF, 32'h2,        32'h0,        32'hFFFFFFFE, 1'b0, 4}   // R4
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic issue(input logic [1:0] op, input logic [1:0] fmt, input logic wide,
                         input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        iss_valid = 1; iss_op = op; iss_fmt = fmt; iss_wide = wide; iss_a = a; iss_b = b;
        @(negedge clk);
        iss_valid = 0;
    endtask

    task automatic read_acc(output logic [31:0] d);
        @(negedge clk);
        rd_req = 1;
        #1;
        while (!rd_valid) begin @(negedge clk); #1; end
        d = rd_data;
        rd_req = 0;
    endtask

    // watchdog: a hung run counts as a failure
    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R13 reset state
        #1;
        chk("R13 ovf", {31'b0, ovf_flag}, 0);
        chk("R13 sat", {31'b0, sat_mode}, 0);
        chk("R12 ready idle", {31'b0, iss_ready}, 1);
        read_acc(got);
        chk("R13 acc", got, 0);

        // vector table
        for (int i = 0; i < 15; i++) begin
            reg_write(1'b1, {30'b0, VECS[i].sat, 1'b0});
            reg_write(1'b0, VECS[i].init);
            issue(VECS[i].op, VECS[i].fmt, VECS[i].wide, VECS[i].a, VECS[i].b);
            read_acc(got);
            chk($sformatf("R%0d vec%0d acc", VECS[i].req, i), got, VECS[i].exp);
            chk($sformatf("R%0d vec%0d ovf", VECS[i].req, i), {31'b0, ovf_flag}, {31'b0, VECS[i].eovf});
        end

        // R2 latency: result appears after the second edge following acceptance
        reg_write(1'b1, 32'h0);
        reg_write(1'b0, 32'h0);
        @(negedge clk);
        iss_valid = 1; iss_op = 0; iss_fmt = 0; iss_wide = 0; iss_a = 3; iss_b = 4;
        @(negedge clk);
        iss_valid = 0; rd_req = 1; #1;
        chk("R2 stage1 busy", {31'b0, rd_valid}, 0);
        @(negedge clk); #1;
        chk("R2 stage2 busy", {31'b0, rd_valid}, 0);
        @(negedge clk); #1;
        chk("R10 read ready", {31'b0, rd_valid}, 1);
        chk("R2 result", rd_data, 12);
        rd_req = 0;

        // R2 back-to-back issue
        reg_write(1'b0, 32'h0);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            iss_valid = 1; iss_op = 2'b01; iss_fmt = 0; iss_wide = 0;
            iss_a = 2 * k + 1; iss_b = 2 * k + 2;
        end
        @(negedge clk);
        iss_valid = 0;
        read_acc(got);
        chk("R2 back-to-back", got, 100);

        // R11 a load between two operations keeps program order
        reg_write(1'b0, 32'h0);
        @(negedge clk);
        iss_valid = 1; iss_op = 2'b01; iss_a = 5; iss_b = 5;
        @(negedge clk);
        iss_valid = 0; wr_en = 1; wr_sel = 0; wr_data = 1000; #1;
        chk("R12 ready during write", {31'b0, iss_ready}, 0);
        @(negedge clk);
        wr_en = 0; iss_valid = 1; iss_op = 2'b01; iss_a = 2; iss_b = 3;
        @(negedge clk);
        iss_valid = 0;
        read_acc(got);
        chk("R11 ordered load", got, 1006);

        // R12 an operation is held while a read is pending
        reg_write(1'b0, 32'd10);
        @(negedge clk);
        rd_req = 1; iss_valid = 1; iss_op = 2'b01; iss_fmt = 0; iss_wide = 0; iss_a = 1; iss_b = 1;
        @(negedge clk); #1;
        chk("R12 ready during read", {31'b0, iss_ready}, 0);
        chk("R12 held op not applied", rd_data, 10);
        rd_req = 0;
        @(negedge clk);
        iss_valid = 0;
        read_acc(got);
        chk("R12 op applied once", got, 11);

        // R9 sticky flag, cleared only by a status write
        reg_write(1'b1, 32'h0);
        reg_write(1'b0, 32'h7FFFFFFF);
        issue(2'b01, 2'b00, 1'b0, 1, 1);
        issue(2'b00, 2'b00, 1'b0, 2, 2);
        read_acc(got);
        chk("R9 acc after mul", got, 4);
        chk("R9 flag sticky", {31'b0, ovf_flag}, 1);
        reg_write(1'b1, 32'h2);
        read_acc(got);
        chk("R9 flag cleared", {31'b0, ovf_flag}, 0);
        chk("R9 sat set", {31'b0, sat_mode}, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule